// File: doc/BRIEF.md
# Block Synchronization Detector with Lock Protection

This block locates block boundaries in a demodulated serial bitstream. Every accepted bit is shifted into a 16-bit window. The window is compared against a small set of fixed identification codes, and a code counts as found when its bit-error count is within a programmable limit. A free-running position counter marks the instant at which the next code is expected to finish.

A two-state protection machine sits on top of the position counter. In the hunting state it needs a run of consecutive on-time detections before it declares lock. In the locked state it needs a run of consecutive on-time misses before it drops lock. Error limits and run lengths are set separately for each state through two 8-bit configuration inputs.

The downstream logic uses the lock flag to know when it can trust the boundaries. It uses the block-start strobe to align its block framing, and the code index to know which code closed the block.

Top module: `blksync_detector`

## Requirements
- R1: A synchronous reset clears the lock flag, the strobe and the code index, zeroes the position counter and the protection counter, and loads the active configuration with tolerance 0x22 and protection 0x17.
- R2: The window shifts only on cycles with bit_en high, and the newest bit enters at bit 0. Code index 0..3 is 16'h3A5C, 16'hC5A3, 16'h5C3A and 16'hA3C5. A code matches when the number of differing bits is at most the current limit. If several codes match, the lowest index wins.
- R3: The error limit is bits 7:4 of the active tolerance while hunting and bits 3:0 while locked.
- R4: The position counter runs modulo 288 bits. The expected instant is the bit that completes 288 bits since the last block start, and every expected instant produces a strobe.
- R5: While hunting, a detection away from the expected instant realigns the position counter to that bit and sets the protection count to 1.
- R6: While hunting, an on-time detection adds one to the count and an on-time miss clears it. Lock is entered, and the count cleared, when the count reaches bits 7:4 of the active protection plus one. With the default this takes two detections.
- R7: While locked, an on-time miss adds one to the count and an on-time detection clears it. Lock is left, and the count cleared, when the count reaches bits 3:0 of the active protection plus one. With the default this takes eight misses. Leaving lock keeps the position counter running.
- R8: While locked, detections away from the expected instant are ignored: no strobe, no realignment, no index change.
- R9: A protection field of 0 makes a single event decisive: the first detection locks, and the first miss unlocks.
- R10: blk_start is high for exactly the one cycle after a bit_en cycle on which a block starts (an expected instant or a realignment). code_idx takes the index of a counted detection in that same cycle and otherwise holds.
- R11: cfg_tol and cfg_prot are copied into the active configuration only at expected instants, after that instant has been evaluated. Changes between expected instants have no effect until then.
- R12: sync_lock, blk_start and code_idx change only in the cycle after a bit_en cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit clock enable; one serial bit per high cycle |
| bit_in | input | 1 | Serial data bit |
| cfg_tol | input | 8 | Error limits: [7:4] hunting, [3:0] locked |
| cfg_prot | input | 8 | Run lengths minus one: [7:4] hunting, [3:0] locked |
| sync_lock | output | 1 | High while block synchronization is held |
| blk_start | output | 1 | One-cycle block-start strobe |
| code_idx | output | 2 | Index of the last counted code |

## Verification
The expected instant and a code detection can land on the same bit. The verdict then depends on lock state, count and mode, and the same edge also copies in new configuration. The bench places codes exactly on the slot, places them off the slot, and changes the configuration between slots, including a detection that realigns just after an instant that latched a new protection value. A bench model built from the requirements predicts every output on every cycle, and directed checks confirm the lock, strobe and index at the instants where they coincide.

// File: rtl/blksync_pkg.sv
package blksync_pkg;
  localparam int CODE_W    = 16;
  localparam int NUM_CODES = 4;
  localparam int FIELD_W   = 4;
  // index 0 in the low bits
  localparam logic [NUM_CODES*CODE_W-1:0] CODE_SET =
    {16'hA3C5, 16'h5C3A, 16'hC5A3, 16'h3A5C};
  localparam logic [2*FIELD_W-1:0] TOL_DEFAULT  = 8'h22;
  localparam logic [2*FIELD_W-1:0] PROT_DEFAULT = 8'h17;
  typedef enum logic {ST_HUNT = 1'b0, ST_LOCK = 1'b1} sync_state_t;
endpackage

// File: rtl/bsd_correlator.sv
module bsd_correlator #(
  parameter int CODE_W    = 16,
  parameter int NUM_CODES = 4,
  parameter int FIELD_W   = 4,
  parameter logic [NUM_CODES*CODE_W-1:0] CODES = '0,
  localparam int ERR_W = $clog2(CODE_W + 1),
  localparam int IDX_W = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1
) (
  input  logic [CODE_W-1:0]  win,
  input  logic [FIELD_W-1:0] limit,
  output logic               det,
  output logic [IDX_W-1:0]   idx
);
  logic [NUM_CODES-1:0] ok;

  // R2: one Hamming-distance comparator per code
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    logic [CODE_W-1:0] diff;
    logic [ERR_W-1:0]  errs;
    assign diff = win ^ CODES[g*CODE_W +: CODE_W];
    always_comb begin
      errs = '0;
      for (int k = 0; k < CODE_W; k++) errs = errs + ERR_W'(diff[k]);
    end
    assign ok[g] = (errs <= ERR_W'(limit));
  end

  // lowest index has priority
  always_comb begin
    det = 1'b0;
    idx = '0;
    for (int i = NUM_CODES - 1; i >= 0; i--) begin
      if (ok[i]) begin
        det = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/bsd_position.sv
module bsd_position #(
  parameter int BLK_LEN = 288,
  localparam int POS_W = $clog2(BLK_LEN)
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic realign,
  output logic expect_now
);
  logic [POS_W-1:0] pos_q;

  assign expect_now = (pos_q == POS_W'(BLK_LEN - 1));

  // R4, R5: free-running modulo counter, realigned on request
  always_ff @(posedge clk) begin
    if (rst)
      pos_q <= '0;
    else if (step) begin
      if (expect_now || realign) pos_q <= '0;
      else                       pos_q <= pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/bsd_protect.sv
module bsd_protect
  import blksync_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int IDX_W   = 2,
  localparam int CNT_W = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               expect_now,
  input  logic               det,
  input  logic [IDX_W-1:0]   det_idx,
  input  logic [2*FIELD_W-1:0] prot_cfg,
  output logic               locked,
  output logic               realign,
  output logic               strobe,
  output logic [IDX_W-1:0]   idx_q
);
  sync_state_t      state_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc, need_hunt, need_lock;

  assign locked    = (state_q == ST_LOCK);
  assign cnt_inc   = cnt_q + 1'b1;
  assign need_hunt = CNT_W'(prot_cfg[2*FIELD_W-1:FIELD_W]) + 1'b1;
  assign need_lock = CNT_W'(prot_cfg[FIELD_W-1:0]) + 1'b1;
  assign realign   = step && !expect_now && !locked && det;   // R5, R8

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      strobe  <= 1'b0;
      idx_q   <= '0;
    end else begin
      strobe <= 1'b0;
      if (step && expect_now) begin
        strobe <= 1'b1;                         // R4, R10
        if (det) idx_q <= det_idx;
        if (!locked) begin                      // R6
          if (!det) cnt_q <= '0;
          else if (cnt_inc >= need_hunt) begin
            state_q <= ST_LOCK;
            cnt_q   <= '0;
          end else cnt_q <= cnt_inc;
        end else begin                          // R7
          if (det) cnt_q <= '0;
          else if (cnt_inc >= need_lock) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
          end else cnt_q <= cnt_inc;
        end
      end else if (realign) begin
        strobe <= 1'b1;
        idx_q  <= det_idx;
        if (need_hunt == CNT_W'(1)) begin       // R9
          state_q <= ST_LOCK;
          cnt_q   <= '0;
        end else cnt_q <= CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/blksync_detector.sv
module blksync_detector
  import blksync_pkg::*;
#(
  parameter int BLK_LEN   = 288,
  parameter int CW        = CODE_W,
  parameter int NC        = NUM_CODES,
  parameter int FW        = FIELD_W,
  parameter logic [NC*CW-1:0] CODES = CODE_SET,
  localparam int CFG_W = 2 * FW,
  localparam int IDX_W = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic [CFG_W-1:0] cfg_tol,
  input  logic [CFG_W-1:0] cfg_prot,
  output logic             sync_lock,
  output logic             blk_start,
  output logic [IDX_W-1:0] code_idx
);
  logic [CW-1:0]    win_q, win_nxt;
  logic [CFG_W-1:0] tol_act, prot_act;
  logic [FW-1:0]    limit;
  logic             det, expect_now, realign;
  logic [IDX_W-1:0] det_idx;

  assign win_nxt = {win_q[CW-2:0], bit_in};          // R2
  assign limit   = sync_lock ? tol_act[FW-1:0] : tol_act[CFG_W-1:FW];  // R3

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= '0;
      tol_act  <= CFG_W'(TOL_DEFAULT);               // R1
      prot_act <= CFG_W'(PROT_DEFAULT);
    end else if (bit_en) begin
      win_q <= win_nxt;
      if (expect_now) begin                          // R11
        tol_act  <= cfg_tol;
        prot_act <= cfg_prot;
      end
    end
  end

  bsd_correlator #(.CODE_W(CW), .NUM_CODES(NC), .FIELD_W(FW), .CODES(CODES)) u_corr (
    .win(win_nxt), .limit(limit), .det(det), .idx(det_idx));

  bsd_position #(.BLK_LEN(BLK_LEN)) u_pos (
    .clk(clk), .rst(rst), .step(bit_en), .realign(realign), .expect_now(expect_now));

  bsd_protect #(.FIELD_W(FW), .IDX_W(IDX_W)) u_prot (
    .clk(clk), .rst(rst), .step(bit_en), .expect_now(expect_now), .det(det),
    .det_idx(det_idx), .prot_cfg(prot_act), .locked(sync_lock), .realign(realign),
    .strobe(blk_start), .idx_q(code_idx));
endmodule

// File: rtl/blksync_detector_chk.sv
module blksync_detector_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic             sync_lock,
  input logic             blk_start,
  input logic [IDX_W-1:0] code_idx
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sync_lock && !blk_start && code_idx == '0)); // R1
  AST_LOCK_ON_BIT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bit_en)) |-> $stable(sync_lock)); // R12
  AST_STROBE_ON_BIT: assert property (@(posedge clk) disable iff (rst)
    blk_start |-> $past(bit_en)); // R10
  AST_LOCK_ENTRY_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(sync_lock)) |-> blk_start); // R6
  AST_LOCK_EXIT_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(sync_lock)) |-> blk_start); // R7
  AST_IDX_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !blk_start) |-> $stable(code_idx)); // R10
endmodule

bind blksync_detector blksync_detector_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .sync_lock(sync_lock),
  .blk_start(blk_start), .code_idx(code_idx));

// File: tb/blksync_detector_test.sv
module blksync_detector_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic [7:0] cfg_tol = 8'h22;
  logic [7:0] cfg_prot = 8'h17;
  logic       sync_lock, blk_start;
  logic [1:0] code_idx;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";
  int gap_pct = 0;

  // model state
  logic [15:0] m_win;
  int m_pos, m_cnt;
  logic [7:0] m_tol, m_prot;
  logic e_lock, e_strobe;
  logic [1:0] e_idx;

  always #10 clk = ~clk;

  blksync_detector uut (.clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .cfg_tol(cfg_tol), .cfg_prot(cfg_prot), .sync_lock(sync_lock),
    .blk_start(blk_start), .code_idx(code_idx));

  function automatic logic [15:0] code_of(int i);
    case (i)
      0: return 16'h3A5C;
      1: return 16'hC5A3;
      2: return 16'h5C3A;
      default: return 16'hA3C5;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_win = '0; m_pos = 0; m_cnt = 0; m_tol = 8'h22; m_prot = 8'h17;
    e_lock = 0; e_strobe = 0; e_idx = 0;
  endtask

  task automatic model_step(logic en, logic b);
    logic [15:0] w;
    int lim, di;
    logic d, ex;
    e_strobe = 0;
    if (!en) return;
    w = {m_win[14:0], b};
    m_win = w;
    lim = e_lock ? int'(m_tol[3:0]) : int'(m_tol[7:4]);
    d = 0; di = 0;
    for (int i = 3; i >= 0; i--)
      if ($countones(w ^ code_of(i)) <= lim) begin d = 1; di = i; end
    ex = (m_pos == 287);
    if (ex) begin
      m_pos = 0; e_strobe = 1;
      if (d) e_idx = 2'(di);
      if (!e_lock) begin
        if (!d) m_cnt = 0;
        else if (m_cnt + 1 >= int'(m_prot[7:4]) + 1) begin e_lock = 1; m_cnt = 0; end
        else m_cnt++;
      end else begin
        if (d) m_cnt = 0;
        else if (m_cnt + 1 >= int'(m_prot[3:0]) + 1) begin e_lock = 0; m_cnt = 0; end
        else m_cnt++;
      end
      m_tol = cfg_tol; m_prot = cfg_prot;
    end else begin
      m_pos++;
      if (!e_lock && d) begin
        m_pos = 0; e_strobe = 1; e_idx = 2'(di);
        if (m_prot[7:4] == 0) begin e_lock = 1; m_cnt = 0; end
        else m_cnt = 1;
      end
    end
  endtask

  task automatic tick(logic en, logic b);
    bit_en = en; bit_in = b;
    model_step(en, b);
    @(negedge clk);
    chk(sync_lock === e_lock, cur_req, "sync_lock", int'(sync_lock), int'(e_lock));
    chk(blk_start === e_strobe, cur_req, "blk_start", int'(blk_start), int'(e_strobe));
    chk(code_idx === e_idx, cur_req, "code_idx", int'(code_idx), int'(e_idx));
  endtask

  task automatic send_bit(logic b);
    if (gap_pct > 0 && ($urandom % 100) < gap_pct) tick(1'b0, 1'($urandom));
    tick(1'b1, b);
  endtask

  task automatic send_zeros(int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic send_rand(int n);
    for (int i = 0; i < n; i++) send_bit(1'($urandom));
  endtask

  task automatic send_code(int idx, int nerr);
    logic [15:0] c, mask;
    mask = '0;
    while ($countones(mask) < nerr) mask = mask | (16'h1 << ($urandom % 16));
    c = code_of(idx) ^ mask;
    for (int i = 15; i >= 0; i--) send_bit(c[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    @(negedge clk);
    chk(sync_lock === 1'b0, "R1", "lock after reset", int'(sync_lock), 0);
    chk(blk_start === 1'b0, "R1", "strobe after reset", int'(blk_start), 0);
    chk(code_idx === 2'd0, "R1", "idx after reset", int'(code_idx), 0);

    // R5, R6: realign then one on-time detection locks
    cur_req = "R5";
    send_zeros(100);
    send_code(0, 0);
    chk(blk_start === 1'b1, "R5", "realign strobe", int'(blk_start), 1);
    chk(sync_lock === 1'b0, "R5", "still hunting", int'(sync_lock), 0);
    tick(1'b1, 1'b0);
    chk(blk_start === 1'b0, "R10", "strobe one cycle", int'(blk_start), 0);
    cur_req = "R6";
    send_zeros(271);
    send_code(1, 0);
    chk(sync_lock === 1'b1, "R6", "lock after two", int'(sync_lock), 1);
    chk(code_idx === 2'd1, "R10", "index of lock code", int'(code_idx), 1);
    // R12: no bit_en, nothing moves
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1);
    chk(sync_lock === 1'b1 && blk_start === 1'b0, "R12", "hold without bit_en",
        int'({sync_lock, blk_start}), 2);

    // R8: off-slot code ignored while locked; R3: 2 errors accepted
    cur_req = "R8";
    send_zeros(100);
    send_code(2, 0);
    chk(blk_start === 1'b0, "R8", "no strobe off-slot", int'(blk_start), 0);
    chk(code_idx === 2'd1, "R8", "index unchanged", int'(code_idx), 1);
    send_zeros(156);
    cur_req = "R3";
    send_code(3, 2);
    chk(sync_lock === 1'b1 && code_idx === 2'd3, "R3", "two-error hit",
        int'(code_idx), 3);
    // R3: locked limit 0, hunting limit 3
    cfg_tol = 8'h30;
    send_zeros(272); send_code(1, 0);      // latches 0x30
    send_zeros(272); send_code(2, 1);      // one error: miss while locked
    chk(code_idx === 2'd1, "R3", "locked limit rejects", int'(code_idx), 1);
    chk(sync_lock === 1'b1, "R3", "one miss keeps lock", int'(sync_lock), 1);
    cfg_tol = 8'h22;
    send_zeros(272); send_code(0, 0);      // hit clears count, latches 0x22

    // R7, R4: eight misses unlock
    cur_req = "R7";
    for (int b = 0; b < 7; b++) begin
      send_zeros(288);
      chk(blk_start === 1'b1, "R4", "flywheel strobe", int'(blk_start), 1);
    end
    chk(sync_lock === 1'b1, "R7", "seven misses", int'(sync_lock), 1);
    send_zeros(288);
    chk(sync_lock === 1'b0, "R7", "eighth miss", int'(sync_lock), 0);

    // R11: new protection not used before next slot
    cur_req = "R11";
    cfg_prot = 8'h00;
    send_zeros(50);
    send_code(0, 0);
    chk(sync_lock === 1'b0, "R11", "old count still active", int'(sync_lock), 0);
    send_zeros(288);                        // miss, latches 0x00
    cur_req = "R9";
    send_zeros(40);
    send_code(2, 0);
    chk(sync_lock === 1'b1, "R9", "single detection locks", int'(sync_lock), 1);
    send_zeros(287);
    chk(sync_lock === 1'b1, "R9", "before slot", int'(sync_lock), 1);
    cfg_prot = 8'h17;
    send_zeros(1);
    chk(sync_lock === 1'b0, "R9", "single miss unlocks", int'(sync_lock), 0);
    send_zeros(30);
    send_code(1, 0);
    chk(sync_lock === 1'b0, "R11", "0x17 active after slot", int'(sync_lock), 0);

    // random blocks with gaps, errors and config changes
    cur_req = "R2";
    gap_pct = 12;
    for (int b = 0; b < 40; b++) begin
      int r;
      r = $urandom % 8;
      if (r == 0) cfg_tol = ($urandom % 2) ? 8'h31 : 8'h22;
      if (r == 1) cfg_prot = ($urandom % 2) ? 8'h13 : 8'h17;
      if (r == 2) cfg_prot = 8'h00;
      if (r == 3) send_rand($urandom % 40);
      send_rand(272);
      if (($urandom % 4) != 0) send_code($urandom % 4, $urandom % 4);
      else send_rand(16);
    end
    gap_pct = 0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule